// File: doc/BRIEF.md
# Signed Serial-by-Parallel Multiplier

This block multiplies a two's-complement operand held in parallel form (PAR_W bits wide) by a two's-complement operand that arrives one bit per clock, least significant bit first. The full-precision product leaves on a single output wire, also least significant bit first, one clock behind the serial input. Internally a row of PAR_W-1 bit-serial adders forms a shifting accumulator. Each adder keeps its own carry and passes its registered sum one position down per clock. A serial negation cell takes the most significant position, so a negative parallel operand is sign-corrected with no extra accumulator width.

Upstream logic sends each serial word sign-extended by PAR_W bits, so that the word is as long as the product. A one-cycle strobe marks the first bit of every word. In that same clock the strobe discards all carries, the negation flag and the accumulator contents. Words can therefore follow each other with no idle cycle. The parallel operand comes from one of two sources, chosen at build time: a fixed parameter, or a register loaded through a load strobe. The hardware grows only with PAR_W. The serial word length is set entirely by the caller.

Top module: `serpar_mult`

## Requirements
- R1: With the serial operand Y (sign-extended to PAR_W+M bits, LSB first) and the parallel operand X, the output stream over one word equals the bits of Y*X modulo 2^(PAR_W+M), LSB first.
- R2: Product bit t is visible on `prod_out` after the clock edge that samples serial bit t, and not before it (latency of one clock); `word_clr` is high together with bit 0.
- R3: Negative parallel operands give correct signed products, including the most negative value (8'h80 at PAR_W=8) against itself and against the largest positive value.
- R4: A word that starts with `word_clr` gives a correct product right after a previous word with no idle cycle between them, whatever carries or negation state that word left behind.
- R5: In register mode (`FIXED_EN`=0), `par_val` is captured at a clock edge where `par_ld` is 1. While `par_ld` is 0, changes on `par_val` have no effect on the product.
- R6: In fixed mode (`FIXED_EN`=1), the parallel operand is the parameter `FIXED_X`, and `par_ld` and `par_val` have no effect.
- R7: After synchronous reset `prod_out` is 0, and it stays 0 while `ser_in` is held at 0.
- R8: A zero parallel operand or a zero serial operand gives an all-zero product word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_clr | input | 1 | High with the first (LSB) bit of each serial word; clears the accumulator state |
| ser_in | input | 1 | Serial operand bit, LSB first, sign-extended by the caller |
| par_ld | input | 1 | Load strobe for the parallel operand register (register mode) |
| par_val | input | PAR_W | Parallel operand value captured on `par_ld` |
| prod_out | output | 1 | Serial product bit, LSB first, one clock after its input bit |

## Verification
Two things fall in the same clock: the last product bit of one word leaves the block while the clear and the first bit of the next word enter it. The bench sends words back to back with no gap under one operand. One pair puts a word with a negative operand, which leaves the negation flag set, directly ahead of another word. Every bit of each word is collected at the falling edge and compared with a signed product computed in the bench, so any state left over from the previous word shows up as a wrong bit in the low part of the next product.

// File: rtl/serpar_pkg.sv
package serpar_pkg;

    // Result of a one-bit full addition
    typedef struct packed {
        logic sum;
        logic carry;
    } fa_res_t;

    // Registered state of the negation cell
    typedef struct packed {
        logic seen_one;
        logic out_bit;
    } neg_state_t;

    function automatic fa_res_t full_add(input logic a, input logic b, input logic c);
        fa_res_t r;
        r.sum   = a ^ b ^ c;
        r.carry = (a & b) | (a & c) | (b & c);
        return r;
    endfunction

    // Serial negation step: copy up to and including the first one, invert after
    function automatic neg_state_t neg_step(input logic seen, input logic din);
        neg_state_t n;
        n.out_bit  = din ^ seen;
        n.seen_one = seen | din;
        return n;
    endfunction

endpackage

// File: rtl/serpar_csa_cell.sv
module serpar_csa_cell
    import serpar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic pp_bit,
    input  logic chain_in,
    output logic sum_q
);
    logic    carry_q;
    logic    chain_eff;
    logic    cin_eff;
    fa_res_t fa;

    // On the clear cycle the old accumulation and carry count as zero
    assign chain_eff = clr ? 1'b0 : chain_in;
    assign cin_eff   = clr ? 1'b0 : carry_q;
    assign fa        = full_add(pp_bit, chain_eff, cin_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= 1'b0;
            carry_q <= 1'b0;
        end else begin
            sum_q   <= fa.sum;
            carry_q <= fa.carry;
        end
    end

    // R4: a clear with no partial-product bit leaves sum and carry at zero
    p_clr_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (clr && !pp_bit) |=> (!sum_q && !carry_q));

endmodule

// File: rtl/serpar_neg_cell.sv
module serpar_neg_cell
    import serpar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic din,
    output logic dout_q
);
    neg_state_t st_q;
    neg_state_t st_d;
    logic       seen_eff;

    assign seen_eff = clr ? 1'b0 : st_q.seen_one;
    assign st_d     = neg_step(seen_eff, din);
    assign dout_q   = st_q.out_bit;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R3: once a one has passed, inversion stays on until the next clear
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q.seen_one && !clr) |=> st_q.seen_one);

    // R3: zeros ahead of the first one pass through unchanged
    p_zero_pass_r3: assert property (@(posedge clk) disable iff (rst)
        ((clr || !st_q.seen_one) && !din) |=> !dout_q);

    // R4: a clear with a zero input leaves the detect flag low
    p_flag_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (clr && !din) |=> !st_q.seen_one);

endmodule

// File: rtl/serpar_operand.sv
module serpar_operand #(
    parameter int               PAR_W    = 8,
    parameter bit               FIXED_EN = 1'b0,
    parameter logic [PAR_W-1:0] FIXED_X  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             par_ld,
    input  logic [PAR_W-1:0] par_val,
    output logic [PAR_W-1:0] x_op
);
    logic [PAR_W-1:0] x_q;

    always_ff @(posedge clk) begin
        if (rst)         x_q <= '0;
        else if (par_ld) x_q <= par_val;
    end

    generate
        if (FIXED_EN) begin : g_fixed
            assign x_op = FIXED_X;
        end else begin : g_reg
            assign x_op = x_q;
        end
    endgenerate

    // R5: without a load strobe the held operand does not move
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !par_ld |=> $stable(x_q));

endmodule

// File: rtl/serpar_mult.sv
module serpar_mult #(
    parameter int               PAR_W    = 8,
    parameter bit               FIXED_EN = 1'b0,
    parameter logic [PAR_W-1:0] FIXED_X  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             word_clr,
    input  logic             ser_in,
    input  logic             par_ld,
    input  logic [PAR_W-1:0] par_val,
    output logic             prod_out
);
    localparam int TOP = PAR_W - 1;

    logic [PAR_W-1:0] x_op;
    logic [PAR_W-1:0] pp;
    logic [PAR_W-1:0] stage_q;

    serpar_operand #(
        .PAR_W    (PAR_W),
        .FIXED_EN (FIXED_EN),
        .FIXED_X  (FIXED_X)
    ) u_operand (
        .clk     (clk),
        .rst     (rst),
        .par_ld  (par_ld),
        .par_val (par_val),
        .x_op    (x_op)
    );

    // Partial-product row: current serial bit gated by each operand bit
    assign pp = {PAR_W{ser_in}} & x_op;

    // Sign position: negation of the serial stream gated by the sign bit
    serpar_neg_cell u_neg (
        .clk    (clk),
        .rst    (rst),
        .clr    (word_clr),
        .din    (pp[TOP]),
        .dout_q (stage_q[TOP])
    );

    // Shifting accumulator: each adder takes the registered sum from above
    generate
        for (genvar i = 0; i < TOP; i++) begin : g_csa
            serpar_csa_cell u_csa (
                .clk      (clk),
                .rst      (rst),
                .clr      (word_clr),
                .pp_bit   (pp[i]),
                .chain_in (stage_q[i+1]),
                .sum_q    (stage_q[i])
            );
        end
    endgenerate

    assign prod_out = stage_q[0];

    initial begin
        p_width_r1: assert (PAR_W >= 2);
    end

    // R7: reset leaves the output low
    p_reset_zero_r7: assert property (@(posedge clk)
        rst |=> !prod_out);

    // R8: a zero operand with a clear gives a zero first product bit
    p_zero_first_r8: assert property (@(posedge clk) disable iff (rst)
        (word_clr && (x_op == '0)) |=> !prod_out);

endmodule

// File: tb/serpar_mult_bench.sv
module serpar_mult_bench;
    localparam int PAR_W = 8;
    localparam int SER_M = 8;
    localparam int WLEN  = PAR_W + SER_M;
    localparam logic [PAR_W-1:0] FX = 8'hFD;   // -3 for the fixed-mode instance
    localparam int NV = 10;

    // Stimulus table: serial operand, parallel operand
    localparam logic [SER_M-1:0] TY [NV] = '{8'd3, 8'hFC, 8'd127, 8'd7, 8'hF8,
                                            8'h80, 8'd127, 8'h80, 8'd0, 8'd25};
    localparam logic [PAR_W-1:0] TX [NV] = '{8'd5, 8'd5, 8'd5, 8'hFF, 8'hFF,
                                            8'h80, 8'h80, 8'd127, 8'h80, 8'd0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic word_clr = 1'b0;
    logic ser_in = 1'b0;
    logic par_ld = 1'b0;
    logic [PAR_W-1:0] par_val = '0;
    logic prod_a, prod_f;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serpar_mult #(.PAR_W(PAR_W), .FIXED_EN(1'b0), .FIXED_X('0)) u_serpar_mult (
        .clk(clk), .rst(rst), .word_clr(word_clr), .ser_in(ser_in),
        .par_ld(par_ld), .par_val(par_val), .prod_out(prod_a));

    serpar_mult #(.PAR_W(PAR_W), .FIXED_EN(1'b1), .FIXED_X(FX)) u_serpar_mult_fixed (
        .clk(clk), .rst(rst), .word_clr(word_clr), .ser_in(ser_in),
        .par_ld(par_ld), .par_val(par_val), .prod_out(prod_f));

    function automatic logic [WLEN-1:0] ref_prod(input logic [SER_M-1:0] y,
                                                 input logic [PAR_W-1:0] x);
        longint p;
        p = longint'($signed(y)) * longint'($signed(x));
        return p[WLEN-1:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_x(input logic [PAR_W-1:0] x);
        par_val = x;
        par_ld  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        par_ld  = 1'b0;
    endtask

    // One word, starting on the current falling edge; returns both outputs
    task automatic run_word(input logic [SER_M-1:0] y,
                            output logic [WLEN-1:0] got_a,
                            output logic [WLEN-1:0] got_f);
        logic [WLEN-1:0] ye;
        ye = {{PAR_W{y[SER_M-1]}}, y};
        for (int t = 0; t < WLEN; t++) begin
            ser_in   = ye[t];
            word_clr = (t == 0);
            @(posedge clk);
            @(negedge clk);
            got_a[t] = prod_a;
            got_f[t] = prod_f;
        end
        ser_in   = 1'b0;
        word_clr = 1'b0;
    endtask

    initial begin
        logic [WLEN-1:0] ga, gf, ea, ef;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R7: reset state, and quiet while serial input is zero
        chk(prod_a == 1'b0 && prod_f == 1'b0, "R7 reset output", {prod_a, prod_f}, 0);
        repeat (4) @(negedge clk);
        chk(prod_a == 1'b0 && prod_f == 1'b0, "R7 idle output", {prod_a, prod_f}, 0);

        // R2: one-clock latency of the first product bit
        load_x(8'd1);
        ser_in = 1'b1; word_clr = 1'b1;
        #1;
        chk(prod_a == 1'b0, "R2 before edge", prod_a, 0);
        @(posedge clk);
        @(negedge clk);
        chk(prod_a == 1'b1, "R2 after edge", prod_a, 1);
        ser_in = 1'b0; word_clr = 1'b0;
        repeat (WLEN) @(negedge clk);

        // Table walk: loads only when the operand changes, so equal-operand
        // entries run back to back (R1, R3, R4, R6, R8)
        for (int v = 0; v < NV; v++) begin
            if (v == 0 || TX[v] != TX[v-1]) load_x(TX[v]);
            run_word(TY[v], ga, gf);
            ea = ref_prod(TY[v], TX[v]);
            ef = ref_prod(TY[v], FX);
            chk(ga == ea, $sformatf("R1 R3 R4 R8 vector %0d", v), ga, ea);
            chk(gf == ef, $sformatf("R6 fixed vector %0d", v), gf, ef);
        end

        // R5: operand held while par_val moves without a load
        load_x(8'd5);
        par_val = 8'hF9;
        run_word(8'd3, ga, gf);
        ea = ref_prod(8'd3, 8'd5);
        chk(ga == ea, "R5 held operand", ga, ea);

        // R5: a new load takes effect for the next word
        load_x(8'hF9);
        run_word(8'd3, ga, gf);
        ea = ref_prod(8'd3, 8'hF9);
        chk(ga == ea, "R5 reloaded operand", ga, ea);
        ef = ref_prod(8'd3, FX);
        chk(gf == ef, "R6 load ignored in fixed mode", gf, ef);

        // R4: negative-operand word then a zero word back to back
        run_word(8'h81, ga, gf);
        run_word(8'd0, ga, gf);
        chk(ga == '0, "R4 R8 zero word after negative", ga, 0);
        chk(gf == '0, "R4 R8 fixed zero word after negative", gf, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule